// File: doc/BRIEF.md
# Erase-Block Read-Merge-Rewrite Sequencer

This engine sits in a flash controller. It applies a host update of one or more pages to an erase block that already holds data. Flash pages cannot be rewritten in place, so a small host write always leads to a full rewrite of the block. The engine first copies every page of the target block into a local buffer. It then overlays the host's new pages on that copy, erases the block, and programs the whole buffer back in ascending page order.

A host starts a rewrite with a one-cycle request that carries the block address. After the copy phase, the host streams its pages into the engine, each with a page index and a last marker. The flash side receives one command at a time and answers each with a done strobe. Two saturating counters record the pages the host supplied and the pages written to flash, so that write amplification can be read off as their ratio. A failed erase or program stops the sequence and raises a sticky error.

Top module: `rmw_block_seq`

## Requirements
- R1: After reset, reqReady is 1, seqDone, errFlag and flCmdValid are 0, pgReady is 0, and both counters are 0.
- R2: A request is taken when reqValid and reqReady are both high. reqReady then stays low until the sequence ends. reqValid and reqBlock are ignored while the sequence is busy.
- R3: The copy phase issues 64 read commands (flCmdOp = 1) for pages 0 to 63 of the requested block, in ascending order. Each command is a single-cycle flCmdValid pulse, and the next one is issued only after flDone has answered the previous one. The read data is taken from flRdData in the flDone cycle.
- R4: After the last read is answered, pgReady goes high. Each cycle with pgValid writes pgData over the buffered copy of page pgIdx, and a later page with the same index wins. The cycle with pgValid and pgLast ends the merge.
- R5: After the merge, exactly one erase command (flCmdOp = 2) for the block is issued. No program command is issued until that erase is answered without failure.
- R6: The program phase issues 64 program commands (flCmdOp = 3) for pages 0 to 63 in ascending order. flCmdData carries the merged buffer content of that page.
- R7: seqDone is high for exactly one cycle after the last program is answered without failure. reqReady is high in the cycle that follows.
- R8: hostPagesWritten increases by one for each page accepted during the merge. flashPagesWritten increases by 64 for each completed rewrite. Both saturate at 2^CNT_W-1.
- R9: If flFail is high together with flDone for an erase or program command, errFlag is set and stays set until reset. No further command is issued, seqDone is not pulsed, flashPagesWritten is unchanged, and the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host rewrite request |
| reqBlock | input | BLK_W | Target erase block |
| reqReady | output | 1 | Engine idle, request can be taken |
| pgValid | input | 1 | Host page present |
| pgIdx | input | log2(PAGES) | Page position of host page |
| pgData | input | DATA_W | Host page content |
| pgLast | input | 1 | Final host page of this request |
| pgReady | output | 1 | Merge phase, host pages accepted |
| flCmdValid | output | 1 | Flash command strobe |
| flCmdOp | output | 2 | 1 read, 2 erase, 3 program |
| flCmdBlock | output | BLK_W | Block addressed by command |
| flCmdPage | output | log2(PAGES) | Page addressed by command |
| flCmdData | output | DATA_W | Program data |
| flDone | input | 1 | Flash command complete |
| flFail | input | 1 | Erase or program failed, valid with flDone |
| flRdData | input | DATA_W | Read data, valid with flDone |
| seqDone | output | 1 | Rewrite completed |
| errFlag | output | 1 | Sticky failure flag |
| hostPagesWritten | output | CNT_W | Saturating host page count |
| flashPagesWritten | output | CNT_W | Saturating flash page count |

## Verification
A wrong page counter or phase state becomes visible on the flash command port at the next command. That command would carry the wrong opcode, page or block, and the bench compares every command against its own expected list. A corrupted buffer entry shows up only in the program phase, about two hundred cycles after the read that filled it, as wrong flCmdData for that page. A counter fault is visible in the cycle after the page accept or after seqDone.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_ALL, ST_MERGE, ST_ERASE, ST_PROGRAM_ALL, ST_DONE
  } seqState_t;

  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;
  localparam logic [1:0] OP_PROG  = 2'd3;

  typedef struct packed {
    logic loadRead;
    logic loadHost;
    logic bumpHost;
    logic bumpFlash;
  } dpStrobe_t;
endpackage

// File: rtl/rmw_buffer_dp.sv
module rmw_buffer_dp
  import rmw_seq_pkg::*;
#(
  parameter int PAGES  = 64,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 10,
  localparam int PAGE_AW = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [PAGE_AW-1:0] pageAddr,
  input  logic [DATA_W-1:0]  rdData,
  input  logic [PAGE_AW-1:0] hostIdx,
  input  logic [DATA_W-1:0]  hostData,
  output logic [DATA_W-1:0]  bufOut,
  output logic [CNT_W-1:0]   hostCount,
  output logic [CNT_W-1:0]   flashCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   PAGE_INC = (CNT_W+1)'(PAGES);

  logic [DATA_W-1:0] pageBuf [PAGES];
  logic [CNT_W:0]    flashSum;

  always_ff @(posedge clk) begin
    if (strobe.loadRead)      pageBuf[pageAddr] <= rdData;
    else if (strobe.loadHost) pageBuf[hostIdx]  <= hostData;
  end

  assign bufOut   = pageBuf[pageAddr];
  assign flashSum = {1'b0, flashCount} + PAGE_INC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostCount  <= '0;
      flashCount <= '0;
    end else begin
      if (strobe.bumpHost && hostCount != CNT_MAX) hostCount <= hostCount + 1'b1;
      if (strobe.bumpFlash)
        flashCount <= flashSum[CNT_W] ? CNT_MAX : flashSum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rmw_seq_ctrl.sv
module rmw_seq_ctrl
  import rmw_seq_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int BLK_W = 4,
  localparam int PAGE_AW = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [BLK_W-1:0]   reqBlock,
  input  logic               pgValid,
  input  logic               pgLast,
  input  logic               flDone,
  input  logic               flFail,
  output logic               reqReady,
  output logic               pgReady,
  output logic               flCmdValid,
  output logic [1:0]         flCmdOp,
  output logic [BLK_W-1:0]   flCmdBlock,
  output logic [PAGE_AW-1:0] pageCnt,
  output logic               seqDone,
  output logic               errFlag,
  output dpStrobe_t          strobe
);
  localparam logic [PAGE_AW-1:0] LAST_PAGE = PAGE_AW'(PAGES - 1);

  seqState_t  state;
  logic       waitDone;
  logic       answered;

  always_comb begin
    reqReady   = (state == ST_IDLE);
    pgReady    = (state == ST_MERGE);
    seqDone    = (state == ST_DONE);
    flCmdValid = !waitDone &&
                 (state == ST_READ_ALL || state == ST_ERASE || state == ST_PROGRAM_ALL);
    unique case (state)
      ST_READ_ALL: flCmdOp = OP_READ;
      ST_ERASE:    flCmdOp = OP_ERASE;
      ST_PROGRAM_ALL: flCmdOp = OP_PROG;
      default:     flCmdOp = 2'd0;
    endcase
    answered         = waitDone && flDone;
    strobe.loadRead  = (state == ST_READ_ALL) && answered;
    strobe.loadHost  = pgReady && pgValid;
    strobe.bumpHost  = pgReady && pgValid;
    strobe.bumpFlash = seqDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pageCnt    <= '0;
      waitDone   <= 1'b0;
      flCmdBlock <= '0;
      errFlag    <= 1'b0;
    end else begin
      if (flCmdValid) waitDone <= 1'b1;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          flCmdBlock <= reqBlock;
          pageCnt    <= '0;
          state      <= ST_READ_ALL;
        end
        ST_READ_ALL: if (answered) begin
          waitDone <= 1'b0;
          if (pageCnt == LAST_PAGE) begin
            pageCnt <= '0;
            state   <= ST_MERGE;
          end else pageCnt <= pageCnt + 1'b1;
        end
        ST_MERGE: if (pgValid && pgLast) state <= ST_ERASE;
        ST_ERASE: if (answered) begin
          waitDone <= 1'b0;
          pageCnt  <= '0;
          if (flFail) begin
            errFlag <= 1'b1;
            state   <= ST_IDLE;
          end else state <= ST_PROGRAM_ALL;
        end
        ST_PROGRAM_ALL: if (answered) begin
          waitDone <= 1'b0;
          if (flFail) begin
            errFlag <= 1'b1;
            state   <= ST_IDLE;
          end else if (pageCnt == LAST_PAGE) state <= ST_DONE;
          else pageCnt <= pageCnt + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_block_seq.sv
module rmw_block_seq
  import rmw_seq_pkg::*;
#(
  parameter int PAGES  = 64,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 4,
  parameter int CNT_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [BLK_W-1:0]         reqBlock,
  output logic                     reqReady,
  input  logic                     pgValid,
  input  logic [$clog2(PAGES)-1:0] pgIdx,
  input  logic [DATA_W-1:0]        pgData,
  input  logic                     pgLast,
  output logic                     pgReady,
  output logic                     flCmdValid,
  output logic [1:0]               flCmdOp,
  output logic [BLK_W-1:0]         flCmdBlock,
  output logic [$clog2(PAGES)-1:0] flCmdPage,
  output logic [DATA_W-1:0]        flCmdData,
  input  logic                     flDone,
  input  logic                     flFail,
  input  logic [DATA_W-1:0]        flRdData,
  output logic                     seqDone,
  output logic                     errFlag,
  output logic [CNT_W-1:0]         hostPagesWritten,
  output logic [CNT_W-1:0]         flashPagesWritten
);
  localparam int PAGE_AW = $clog2(PAGES);

  dpStrobe_t          strobe;
  logic [PAGE_AW-1:0] pageCnt;

  rmw_seq_ctrl #(.PAGES(PAGES), .BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBlock(reqBlock),
    .pgValid(pgValid), .pgLast(pgLast), .flDone(flDone), .flFail(flFail),
    .reqReady(reqReady), .pgReady(pgReady), .flCmdValid(flCmdValid),
    .flCmdOp(flCmdOp), .flCmdBlock(flCmdBlock), .pageCnt(pageCnt),
    .seqDone(seqDone), .errFlag(errFlag), .strobe(strobe)
  );

  rmw_buffer_dp #(.PAGES(PAGES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pageAddr(pageCnt),
    .rdData(flRdData), .hostIdx(pgIdx), .hostData(pgData), .bufOut(flCmdData),
    .hostCount(hostPagesWritten), .flashCount(flashPagesWritten)
  );

  assign flCmdPage = pageCnt;
endmodule

// File: rtl/rmw_block_seq_chk.sv
module rmw_block_seq_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             pgReady,
  input logic             flCmdValid,
  input logic             flDone,
  input logic             flFail,
  input logic             seqDone,
  input logic             errFlag,
  input logic [CNT_W-1:0] hostPagesWritten,
  input logic [CNT_W-1:0] flashPagesWritten
);
  assert_busy_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));
  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    flCmdValid |=> !flCmdValid);
  assert_merge_after_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgReady) |-> $past(flDone));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);
  assert_host_mono_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostPagesWritten >= $past(hostPagesWritten));
  assert_flash_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flashPagesWritten) |-> $past(seqDone));
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(flDone && flFail));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFlag) |-> errFlag);
endmodule

bind rmw_block_seq rmw_block_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .pgReady(pgReady), .flCmdValid(flCmdValid), .flDone(flDone), .flFail(flFail),
  .seqDone(seqDone), .errFlag(errFlag), .hostPagesWritten(hostPagesWritten),
  .flashPagesWritten(flashPagesWritten)
);

// File: tb/rmw_block_seq_bench.sv
module rmw_block_seq_bench;
  localparam int PAGES = 64, DATA_W = 8, BLK_W = 4, CNT_W = 10;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, pgValid = 0, pgLast = 0, flDone = 0, flFail = 0;
  logic [BLK_W-1:0] reqBlock = '0;
  logic [5:0] pgIdx = '0;
  logic [DATA_W-1:0] pgData = '0, flRdData = '0;
  logic reqReady, pgReady, flCmdValid, seqDone, errFlag;
  logic [1:0] flCmdOp;
  logic [BLK_W-1:0] flCmdBlock;
  logic [5:0] flCmdPage;
  logic [DATA_W-1:0] flCmdData;
  logic [CNT_W-1:0] hostPagesWritten, flashPagesWritten;

  always #2.5 clk = ~clk;

  rmw_block_seq u_rmw_block_seq (.*);

  int errors = 0, checks = 0;
  int mem [16][64];
  int qOp[$], qPage[$], qData[$];
  int qBlk, failOp = 0, failPage = 0;
  int hostExp = 0, flashExp = 0;
  int hIdx [64], hDat [64];
  bit pending = 0;
  int pOp, pPage, pBlk, pData;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // flash responder: one-cycle latency, compares every command to the expected list
  initial begin
    forever begin
      @(negedge clk);
      flDone = 0; flFail = 0; flRdData = '0;
      if (pending) begin
        flDone = 1;
        pending = 0;
        if (pOp == 1) flRdData = DATA_W'(mem[pBlk][pPage]);
        else if (pOp == 2) begin
          if (failOp == 2) flFail = 1;
          else for (int p = 0; p < PAGES; p++) mem[pBlk][p] = 255;
        end else if (pOp == 3) begin
          if (failOp == 3 && pPage == failPage) flFail = 1;
          else mem[pBlk][pPage] = pData;
        end
      end else if (flCmdValid) begin
        pOp = flCmdOp; pPage = flCmdPage; pBlk = flCmdBlock; pData = flCmdData;
        pending = 1;
        if (qOp.size() == 0) chk(0, "R9", "unexpected command op", pOp, 0);
        else begin
          int eo, ep, ed;
          string rq;
          eo = qOp.pop_front(); ep = qPage.pop_front(); ed = qData.pop_front();
          rq = (eo == 1) ? "R3" : (eo == 2) ? "R5" : "R6";
          chk(pOp == eo, rq, "opcode", pOp, eo);
          chk(pBlk == qBlk, rq, "block", pBlk, qBlk);
          if (eo != 2) chk(pPage == ep, rq, "page", pPage, ep);
          if (eo == 3) chk(pData == ed, rq, "program data", pData, ed);
        end
      end
    end
  end

  task automatic doRewrite(int blk, int n, int fOp, int fPage, bit pokeBusy);
    int merged [64];
    bit sawDone = 0;
    int waitCnt = 0;
    int flashBefore;
    for (int p = 0; p < PAGES; p++) merged[p] = mem[blk][p];
    for (int i = 0; i < n; i++) merged[hIdx[i]] = hDat[i];
    qBlk = blk; failOp = fOp; failPage = fPage;
    for (int p = 0; p < PAGES; p++) begin qOp.push_back(1); qPage.push_back(p); qData.push_back(0); end
    qOp.push_back(2); qPage.push_back(0); qData.push_back(0);
    if (fOp != 2)
      for (int p = 0; p < PAGES; p++) begin
        if (fOp == 3 && p > fPage) break;
        qOp.push_back(3); qPage.push_back(p); qData.push_back(merged[p]);
      end
    @(negedge clk);
    chk(reqReady == 1, "R2", "ready before request", reqReady, 1);
    reqValid = 1; reqBlock = BLK_W'(blk);
    @(negedge clk);
    chk(reqReady == 0, "R2", "ready after accept", reqReady, 0);
    if (pokeBusy) reqBlock = BLK_W'(blk ^ 1); else reqValid = 0;
    while (!pgReady) @(negedge clk);
    reqValid = 0;
    chk(reqReady == 0, "R2", "ready in merge", reqReady, 0);
    for (int i = 0; i < n; i++) begin
      pgValid = 1; pgIdx = 6'(hIdx[i]); pgData = DATA_W'(hDat[i]); pgLast = (i == n - 1);
      @(negedge clk);
      hostExp = sat(hostExp + 1);
      chk(hostPagesWritten == CNT_W'(hostExp), "R8", "host count", hostPagesWritten, hostExp);
    end
    pgValid = 0; pgLast = 0;
    chk(pgReady == 0, "R4", "merge closed by last page", pgReady, 0);
    flashBefore = flashExp;
    while (!reqReady && waitCnt < 2000) begin
      if (seqDone) sawDone = 1;
      @(negedge clk);
      waitCnt++;
    end
    if (fOp == 0) begin
      flashExp = sat(flashExp + PAGES);
      chk(sawDone, "R7", "done pulse seen", sawDone, 1);
      chk(seqDone == 0, "R7", "done one cycle", seqDone, 0);
      chk(qOp.size() == 0, "R6", "all programs issued", qOp.size(), 0);
    end else begin
      chk(!sawDone, "R9", "no done on failure", sawDone, 0);
      chk(errFlag == 1, "R9", "error flag", errFlag, 1);
      chk(flashExp == flashBefore, "R9", "flash model unchanged", flashExp, flashBefore);
    end
    chk(flashPagesWritten == CNT_W'(flashExp), "R8", "flash count", flashPagesWritten, flashExp);
    chk(hostPagesWritten == CNT_W'(hostExp), "R8", "host count after", hostPagesWritten, hostExp);
    repeat (6) @(negedge clk);
    chk(reqReady == 1, "R2", "idle after sequence", reqReady, 1);
    qOp.delete(); qPage.delete(); qData.delete();
  endtask

  initial begin
    for (int b = 0; b < 16; b++)
      for (int p = 0; p < PAGES; p++) mem[b][p] = (b * 37 + p * 11 + 5) % 251;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(reqReady == 1, "R1", "ready in reset", reqReady, 1);
        rstN = 1;
        @(negedge clk);
        chk(reqReady == 1 && pgReady == 0, "R1", "ready/pgReady", {pgReady, reqReady}, 1);
        chk(seqDone == 0 && errFlag == 0 && flCmdValid == 0, "R1", "done/err/cmd", {seqDone, errFlag, flCmdValid}, 0);
        chk(hostPagesWritten == 0 && flashPagesWritten == 0, "R1", "counters", hostPagesWritten + flashPagesWritten, 0);
        // single page into block 3
        hIdx[0] = 5; hDat[0] = 200;
        doRewrite(3, 1, 0, 0, 0);
        chk(errFlag == 0, "R9", "no error on success", errFlag, 0);
        // edge pages and duplicate index (last wins), busy request poked
        hIdx[0] = 0; hDat[0] = 17; hIdx[1] = 63; hDat[1] = 90; hIdx[2] = 63; hDat[2] = 91;
        doRewrite(3, 3, 0, 0, 1);
        chk(mem[3][63] == 91 && mem[3][5] == 200, "R4", "merged contents", mem[3][63], 91);
        // erase failure
        hIdx[0] = 2; hDat[0] = 1; hIdx[1] = 3; hDat[1] = 2;
        doRewrite(5, 2, 2, 0, 0);
        // program failure at page 10
        hIdx[0] = 40; hDat[0] = 77;
        doRewrite(6, 1, 3, 10, 0);
        // full-block rewrites until both counters saturate; error stays sticky
        for (int k = 0; k < 16; k++) begin
          for (int i = 0; i < PAGES; i++) begin hIdx[i] = i; hDat[i] = (i * 3 + k) % 256; end
          doRewrite(1, PAGES, 0, 0, 0);
          chk(errFlag == 1, "R9", "sticky error", errFlag, 1);
        end
        chk(flashPagesWritten == CNT_W'(CMAX), "R8", "flash saturated", flashPagesWritten, CMAX);
        chk(hostPagesWritten == CNT_W'(CMAX), "R8", "host saturated", hostPagesWritten, CMAX);
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R7", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule